// File: doc/BRIEF.md
# Grouped Reset Request Controller

This block collects reset requests from four kinds of source and turns them into three separate reset group outputs, plus one reset line per peripheral. The sources are an active-low external reset pin, a one-cycle watchdog overflow pulse, a low-supply detection flag that counts only while its reset enable is set, and one software reset bit per peripheral. Each group has its own set of member sources and its own release behaviour. The hard group H0 stays asserted for a programmable number of clock cycles after its last request. The groups H1 and S0 release on the first clock edge after their request goes away.

The external pin and the supply flag are asynchronous, so each passes through a two-flop synchronizer first. The pin also passes a minimum-width filter, which drops short glitches. A sticky cause register records which sources have requested an H0 reset. Software clears each bit by writing a one to it. The controller's own `rst` input is its power-on reset. While `rst` is high, every output is forced asserted.

Top module: `rstgrp_ctrl`

## Requirements
- R1: While `rst` is high, `h0_rst`, `h1_rst`, `s0_rst` and every `per_rst` bit read 1 and `cause_o` reads 0. Counting from the clock cycle after the last edge with `rst` high, `h0_rst` stays high for HOLD_CYC+1 cycles and the other outputs stay high for 1 cycle.
- R2: If `ext_rst_n` is sampled low on MIN_LOW or fewer consecutive clock edges, no output changes and `cause_o` stays 0.
- R3: If `ext_rst_n` is sampled low on L ≥ MIN_LOW+1 consecutive edges, `h1_rst`, `s0_rst` and every `per_rst` bit are each high for exactly L−MIN_LOW cycles.
- R4: A one-cycle `wdt_ovf` pulse asserts `h0_rst` and `h1_rst` on the next clock edge. It leaves `s0_rst` and `per_rst` low, and `h1_rst` is high for exactly one cycle.
- R5: While `lvd_rst_en` is 0, `lvd_det` has no effect. While it is 1, holding `lvd_det` high for D edges asserts only `h0_rst`, for D+HOLD_CYC cycles.
- R6: `h0_rst` stays high for HOLD_CYC cycles after the last cycle in which any of its sources (pin, watchdog, enabled supply flag) requested. A new request that arrives during the hold restarts the full hold.
- R7: `h1_rst` and `s0_rst` fall on the first clock edge after their request ends, with no hold.
- R8: While `sw_rst[i]` is high, `per_rst[i]` is high, but only for peripherals whose bit in SWR_MASK is 1. Software reset bits never affect `h0_rst`, `h1_rst` or `s0_rst`.
- R9: `cause_o` bit 0 records the pin, bit 1 the watchdog and bit 2 the supply source. A bit is set by its request and then holds. It clears only when `cause_clr_we` is high with the matching bit of `cause_clr` set. If a set and a clear hit the same bit in the same cycle, the set wins.
- R10: The groups nest: `s0_rst` high implies `h1_rst` high, and `h1_rst` high implies `h0_rst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Boot clock |
| rst | input | 1 | Synchronous active-high power-on reset of the controller |
| ext_rst_n | input | 1 | Asynchronous active-low external reset pin |
| wdt_ovf | input | 1 | Watchdog overflow pulse, synchronous |
| lvd_det | input | 1 | Asynchronous low-supply detection flag |
| lvd_rst_en | input | 1 | Enables reset from the low-supply flag |
| sw_rst | input | NPER | Per-peripheral software reset bits |
| cause_clr_we | input | 1 | Write strobe for clearing the cause register |
| cause_clr | input | 3 | Write-one-to-clear mask for the cause register |
| h0_rst | output | 1 | Hard group reset with hold time |
| h1_rst | output | 1 | Second hard group reset, immediate release |
| s0_rst | output | 1 | Soft group reset, immediate release |
| per_rst | output | NPER | Per-peripheral reset lines |
| cause_o | output | 3 | Sticky reset cause bits |

## Verification
The group outputs are tried with five input patterns:
- a pin pulse exactly at the filter width,
- a pin pulse one sample longer, and a pin pulse five samples longer,
- single and repeated watchdog pulses,
- the supply flag with the enable both off and on,
- all software reset bits at once.

For each pattern, the bench compares the number of cycles each output spends high against the number computed from the requirements. The count at the filter threshold separates an off-by-one in the width filter. The counts for the watchdog and the supply flag separate the held group from the immediate groups and expose wrong group membership. The repeated watchdog pulse shows whether the hold counter is reloaded or extended. A separate sequence writes to the cause register to check that clearing one bit leaves the others alone and that a set wins over a clear in the same cycle.

// File: rtl/rstgrp_pkg.sv
package rstgrp_pkg;
  localparam int CAUSE_PIN = 0;
  localparam int CAUSE_WDT = 1;
  localparam int CAUSE_LVD = 2;
  localparam int NCAUSE    = 3;
  typedef logic [NCAUSE-1:0] cause_t;
endpackage

// File: rtl/rstgrp_sync.sv
module rstgrp_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rstgrp_pinflt.sv
module rstgrp_pinflt #(
  parameter int MIN_LOW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic low_i,
  output logic req_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (!low_i) begin
      run_cnt <= '0;
    end else if (run_cnt != LIMIT) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign req_o = low_i && (run_cnt == LIMIT);

  // R2: a request can only begin after the pin has been low in the previous cycle too
  a_r2_min_width: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> $past(low_i));
endmodule

// File: rtl/rstgrp_hold.sv
module rstgrp_hold #(
  parameter int HOLD_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic rst_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] FULL = HW'(HOLD_CYC);

  logic [HW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left  <= FULL;
      rst_o <= 1'b1;
    end else begin
      rst_o <= req_i || (left != '0);
      if (req_i)
        left <= FULL;
      else if (left != '0)
        left <= left - 1'b1;
    end
  end

  // R6: every request keeps the output asserted in the following cycle
  a_r6_req_holds: assert property (@(posedge clk) disable iff (rst)
    req_i |=> rst_o);
endmodule

// File: rtl/rstgrp_ctrl.sv
module rstgrp_ctrl
  import rstgrp_pkg::*;
#(
  parameter int MIN_LOW  = 16,
  parameter int HOLD_CYC = 1024,
  parameter int NPER     = 4,
  parameter logic [NPER-1:0] SWR_MASK = NPER'('hB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_rst_n,
  input  logic            wdt_ovf,
  input  logic            lvd_det,
  input  logic            lvd_rst_en,
  input  logic [NPER-1:0] sw_rst,
  input  logic            cause_clr_we,
  input  logic [2:0]      cause_clr,
  output logic            h0_rst,
  output logic            h1_rst,
  output logic            s0_rst,
  output logic [NPER-1:0] per_rst,
  output logic [2:0]      cause_o
);
  logic   pin_low, lvd_s, pin_req, lvd_req;
  logic   h0_req, h1_req, s0_req;
  cause_t cause_q, cause_set, cause_keep;

  rstgrp_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({lvd_det, ~ext_rst_n}),
    .q   ({lvd_s, pin_low})
  );

  rstgrp_pinflt #(.MIN_LOW(MIN_LOW)) u_pinflt (
    .clk   (clk),
    .rst   (rst),
    .low_i (pin_low),
    .req_o (pin_req)
  );

  assign lvd_req = lvd_s && lvd_rst_en;
  assign h0_req  = pin_req || wdt_ovf || lvd_req;
  assign h1_req  = pin_req || wdt_ovf;
  assign s0_req  = pin_req;

  rstgrp_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .req_i (h0_req),
    .rst_o (h0_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h1_rst <= 1'b1;
      s0_rst <= 1'b1;
    end else begin
      h1_rst <= h1_req;
      s0_rst <= s0_req;
    end
  end

  for (genvar i = 0; i < NPER; i++) begin : g_per
    if (SWR_MASK[i]) begin : g_sw
      always_ff @(posedge clk) begin
        if (rst) per_rst[i] <= 1'b1;
        else     per_rst[i] <= s0_req || sw_rst[i];
      end
      // R8: a peripheral with software reset still follows the soft group
      a_r8_sw_follows_s0: assert property (@(posedge clk) disable iff (rst)
        s0_rst |-> per_rst[i]);
    end else begin : g_nosw
      always_ff @(posedge clk) begin
        if (rst) per_rst[i] <= 1'b1;
        else     per_rst[i] <= s0_req;
      end
      // R8: a peripheral without software reset is reset only with the soft group
      a_r8_nosw_ignored: assert property (@(posedge clk) disable iff (rst)
        per_rst[i] |-> s0_rst);
    end
  end

  always_comb begin
    cause_set            = '0;
    cause_set[CAUSE_PIN] = pin_req;
    cause_set[CAUSE_WDT] = wdt_ovf;
    cause_set[CAUSE_LVD] = lvd_req;
    cause_keep           = cause_clr_we ? ~cause_clr : '1;
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= (cause_q & cause_keep) | cause_set;
  end

  assign cause_o = cause_q;

  // R10: nesting of the three groups
  a_r10_h1_in_h0: assert property (@(posedge clk) disable iff (rst)
    h1_rst |-> h0_rst);
  a_r10_s0_in_h1: assert property (@(posedge clk) disable iff (rst)
    s0_rst |-> h1_rst);
  // R6: the held group never releases before or together with the immediate group
  a_r6_h0_outlasts: assert property (@(posedge clk) disable iff (rst)
    $fell(h0_rst) |-> (!h1_rst && !$past(h1_rst)));
  // R9: a cause bit that is not cleared stays set
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & cause_keep) != '0) |=>
      ((cause_q & $past(cause_q & cause_keep)) == $past(cause_q & cause_keep)));
endmodule

// File: tb/test_rstgrp_ctrl.sv
module test_rstgrp_ctrl;
  localparam int MINW = 4;
  localparam int HOLD = 8;
  localparam int NPER = 4;
  localparam logic [NPER-1:0] MASK = 4'b1011;
  localparam int WIN  = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst = 1'b1;
  logic            ext_rst_n = 1'b1;
  logic            wdt_ovf = 1'b0;
  logic            lvd_det = 1'b0;
  logic            lvd_rst_en = 1'b0;
  logic [NPER-1:0] sw_rst = '0;
  logic            cause_clr_we = 1'b0;
  logic [2:0]      cause_clr = '0;
  logic            h0_rst, h1_rst, s0_rst;
  logic [NPER-1:0] per_rst;
  logic [2:0]      cause_o;

  rstgrp_ctrl #(.MIN_LOW(MINW), .HOLD_CYC(HOLD), .NPER(NPER), .SWR_MASK(MASK)) i_rstgrp_ctrl (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .wdt_ovf(wdt_ovf),
    .lvd_det(lvd_det), .lvd_rst_en(lvd_rst_en), .sw_rst(sw_rst),
    .cause_clr_we(cause_clr_we), .cause_clr(cause_clr),
    .h0_rst(h0_rst), .h1_rst(h1_rst), .s0_rst(s0_rst),
    .per_rst(per_rst), .cause_o(cause_o)
  );

  int n_run = 0;
  int n_fail = 0;

  // free-running high-cycle counters, sampled away from the active edge
  int c_h0 = 0, c_h1 = 0, c_s0 = 0;
  int c_per [NPER];
  initial for (int i = 0; i < NPER; i++) c_per[i] = 0;
  always @(negedge clk) begin
    if (h0_rst) c_h0++;
    if (h1_rst) c_h1++;
    if (s0_rst) c_s0++;
    for (int i = 0; i < NPER; i++) if (per_rst[i]) c_per[i]++;
  end

  typedef struct {
    string      tag;
    int         h0, h1, s0;
    int         per [NPER];
    logic [2:0] cause;
  } exp_t;

  exp_t q[$];
  event done_ev;
  int s_h0, s_h1, s_s0;
  int s_per [NPER];
  int m_h0, m_h1, m_s0;
  int m_per [NPER];
  logic [2:0] m_cause;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic exp_t mk(input string t, input int h0, input int h1, input int s0,
                              input int pin_cnt, input int sw_cnt, input logic [2:0] c);
    exp_t e;
    e.tag = t; e.h0 = h0; e.h1 = h1; e.s0 = s0; e.cause = c;
    for (int i = 0; i < NPER; i++) e.per[i] = pin_cnt + (MASK[i] ? sw_cnt : 0);
    return e;
  endfunction

  // monitor: pops the expected item and compares it with the measured window
  initial begin
    forever begin
      exp_t e;
      @(done_ev);
      e = q.pop_front();
      chk(m_h0 == e.h0, e.tag, "h0 high cycles", m_h0, e.h0);
      chk(m_h1 == e.h1, e.tag, "h1 high cycles", m_h1, e.h1);
      chk(m_s0 == e.s0, e.tag, "s0 high cycles", m_s0, e.s0);
      for (int i = 0; i < NPER; i++)
        chk(m_per[i] == e.per[i], e.tag, $sformatf("per_rst[%0d] high cycles", i),
            m_per[i], e.per[i]);
      chk(m_cause == e.cause, e.tag, "cause", int'(m_cause), int'(e.cause));
      chk(m_h1 <= m_h0 && m_s0 <= m_h1, "R10", "group nesting h1<=h0", m_h1, m_h0);
    end
  end

  task automatic snap();
    s_h0 = c_h0; s_h1 = c_h1; s_s0 = c_s0;
    for (int i = 0; i < NPER; i++) s_per[i] = c_per[i];
  endtask

  task automatic begin_case(input exp_t e);
    @(posedge clk); #1;
    cause_clr_we = 1'b1; cause_clr = 3'b111;
    @(posedge clk); #1;
    cause_clr_we = 1'b0; cause_clr = '0;
    q.push_back(e);
    snap();
  endtask

  task automatic end_case();
    repeat (WIN) @(posedge clk);
    #1;
    m_h0 = c_h0 - s_h0; m_h1 = c_h1 - s_h1; m_s0 = c_s0 - s_s0;
    for (int i = 0; i < NPER; i++) m_per[i] = c_per[i] - s_per[i];
    m_cause = cause_o;
    ->done_ev;
    #1;
  endtask

  task automatic pin_low(input int n);
    ext_rst_n = 1'b0;
    repeat (n) @(posedge clk);
    #1 ext_rst_n = 1'b1;
  endtask

  task automatic wdt_pulse();
    wdt_ovf = 1'b1;
    @(posedge clk);
    #1 wdt_ovf = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    // R1: state while held in reset, then release counts
    repeat (3) @(posedge clk);
    #1;
    chk(h0_rst && h1_rst && s0_rst, "R1", "groups in reset", int'({h0_rst, h1_rst, s0_rst}), 7);
    chk(per_rst == '1, "R1", "per_rst in reset", int'(per_rst), 15);
    chk(cause_o == 3'b000, "R1", "cause in reset", int'(cause_o), 0);
    q.push_back(mk("R1", HOLD + 1, 1, 1, 1, 0, 3'b000));
    snap();
    rst = 1'b0;
    end_case();

    // R2: pulse exactly at the filter width is ignored
    begin_case(mk("R2", 0, 0, 0, 0, 0, 3'b000));
    pin_low(MINW);
    end_case();

    // R3: one sample past the threshold
    begin_case(mk("R3 R6 R7", HOLD + 1, 1, 1, 1, 0, 3'b001));
    pin_low(MINW + 1);
    end_case();

    // R3: longer pin pulse
    begin_case(mk("R3 R6 R10", HOLD + 5, 5, 5, 5, 0, 3'b001));
    pin_low(MINW + 5);
    end_case();

    // R4: single watchdog pulse
    begin_case(mk("R4 R7", HOLD + 1, 1, 0, 0, 0, 3'b010));
    wdt_pulse();
    end_case();

    // R6: second pulse during hold reloads the counter
    begin_case(mk("R6", HOLD + 5, 2, 0, 0, 0, 3'b010));
    wdt_pulse();
    repeat (3) @(posedge clk);
    #1 wdt_pulse();
    end_case();

    // R5: supply flag with reset disabled
    begin_case(mk("R5", 0, 0, 0, 0, 0, 3'b000));
    lvd_rst_en = 1'b0;
    lvd_det = 1'b1;
    repeat (6) @(posedge clk);
    #1 lvd_det = 1'b0;
    end_case();

    // R5: supply flag with reset enabled
    lvd_rst_en = 1'b1;
    begin_case(mk("R5 R6", HOLD + 6, 0, 0, 0, 0, 3'b100));
    lvd_det = 1'b1;
    repeat (6) @(posedge clk);
    #1 lvd_det = 1'b0;
    end_case();
    lvd_rst_en = 1'b0;

    // R8: all software bits, only supported peripherals react
    begin_case(mk("R8", 0, 0, 0, 0, 3, 3'b000));
    sw_rst = '1;
    repeat (3) @(posedge clk);
    #1 sw_rst = '0;
    end_case();

    // R9: sticky bits, selective clear, set beats clear
    @(posedge clk); #1;
    cause_clr_we = 1'b1; cause_clr = 3'b111;
    @(posedge clk); #1;
    cause_clr_we = 1'b0; cause_clr = '0;
    wdt_pulse();
    repeat (3) @(posedge clk);
    #1;
    chk(cause_o == 3'b010, "R9", "cause after watchdog", int'(cause_o), 2);
    cause_clr_we = 1'b1; cause_clr = 3'b001;
    @(posedge clk); #1;
    cause_clr_we = 1'b0; cause_clr = '0;
    chk(cause_o == 3'b010, "R9", "cause after clearing other bit", int'(cause_o), 2);
    cause_clr_we = 1'b1; cause_clr = 3'b010;
    @(posedge clk); #1;
    cause_clr_we = 1'b0; cause_clr = '0;
    chk(cause_o == 3'b000, "R9", "cause after clearing its bit", int'(cause_o), 0);
    cause_clr_we = 1'b1; cause_clr = 3'b010; wdt_ovf = 1'b1;
    @(posedge clk); #1;
    cause_clr_we = 1'b0; cause_clr = '0; wdt_ovf = 1'b0;
    chk(cause_o == 3'b010, "R9", "set wins over clear", int'(cause_o), 2);
    repeat (HOLD + 4) @(posedge clk);
    #1;
    chk(!h0_rst && !h1_rst, "R6", "released after hold", int'({h0_rst, h1_rst}), 0);

    summary();
    $finish;
  end
endmodule